// File: doc/BRIEF.md
# SDRAM Command Timing Sequencer

This block turns single access requests into the SDRAM control-line commands that carry them out. It drives the row strobe, column strobe, write enable and clock enable, and it counts every gap between commands from programmable fields. Each access opens a row, issues one read or write, and closes the row again. So between accesses no row is ever left open.

The first access after an arm event runs an initialization sequence before the access itself. The block also keeps a programmable refresh interval counter. It can place the device in self-refresh and bring it back out when a request arrives. It captures read data after the configured CAS latency. Status outputs report whether the block is idle, in self-refresh, or running the initialization sequence, and a sticky error bit flags a self-refresh request that was refused.

Top module: `sdram_cmd_seq`

## Requirements
- R1: Commands are encoded on {ras_n, cas_n, we_n} as follows: NOP 111, activate 011, read 101, write 100, precharge 010, refresh 001, mode register set 000. NOP is driven in every cycle in which no other command is issued. Reset drives NOP with cke high.
- R2: Reset leaves the initialization sequence armed, and a pulse on pwr_arm re-arms it. The next request then first issues precharge, then mode register set tRP cycles later, then 8 refreshes. The first refresh follows the mode register set by tRP cycles, and each later one follows the previous refresh by tRAS+tRP cycles. The activate for the request comes tRAS+tRP cycles after the last refresh.
- R3: st_pwrup rises together with the initialization precharge, stays high through the mode register set, and is low again from the last initialization refresh onward.
- R4: A read or write command follows its activate by exactly tRCD cycles. req_ack is high in exactly that cycle, and req_write selects write (1) or read (0).
- R5: The precharge that closes an access comes max(tRAS, tRCD+1) cycles after the activate for a read, and max(tRAS, tRCD+tWR) cycles after the activate for a write.
- R6: An activate that follows a closing precharge comes exactly tRP cycles after it when a request is already waiting.
- R7: rd_valid pulses CL cycles after the read command, where CL is 3 when cfg_cl3=1 and 2 otherwise. rd_data then holds the value dq_in had at the clock edge CL cycles after the edge that issued the read.
- R8: A timing field programmed to 0 behaves as 1 cycle.
- R9: A sref_req pulse, when no initialization is armed or running, makes the idle block issue refresh with cke low. st_sref is then high and only NOP is driven while cke stays low.
- R10: A request during self-refresh raises cke with a NOP, which is the exit. The activate follows tRP cycles later, and st_sref is low after the exit.
- R11: With cfg_refi nonzero, an auto-refresh becomes due every cfg_refi+1 cycles. It is served as a precharge, then a refresh tRP cycles later, and no activate comes sooner than tRAS+tRP cycles after that refresh. With cfg_refi=0 no refresh is generated.
- R12: st_idle is high when no command sequence or timing wait is in progress, and low during an access and during self-refresh.
- R13: A sref_req while initialization is armed or running is ignored and sets st_err. st_err holds until an err_clr pulse clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_cl3 | input | 1 | CAS latency select: 1 gives 3 cycles, 0 gives 2 |
| cfg_tras | input | TRAS_W | Activate-to-precharge minimum, in cycles |
| cfg_trp | input | TRP_W | Precharge-to-command gap, in cycles |
| cfg_trcd | input | TRCD_W | Activate-to-read/write gap, in cycles |
| cfg_twr | input | TWR_W | Write-to-precharge recovery, in cycles |
| cfg_refi | input | REFI_W | Refresh interval; 0 disables refresh |
| pwr_arm | input | 1 | Pulse that arms the initialization sequence |
| sref_req | input | 1 | Pulse that requests self-refresh entry |
| err_clr | input | 1 | Pulse that clears st_err |
| req_valid | input | 1 | Access request, held until req_ack |
| req_write | input | 1 | 1 for write, 0 for read |
| req_ack | output | 1 | Read or write command issued for the request |
| dq_in | input | DW | Read data from the memory |
| rd_data | output | DW | Captured read data |
| rd_valid | output | 1 | rd_data is new this cycle |
| cke | output | 1 | Clock enable to the memory |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| st_idle | output | 1 | Sequencer idle |
| st_sref | output | 1 | Self-refresh active |
| st_pwrup | output | 1 | Initialization sequence running |
| st_err | output | 1 | Sticky error: self-refresh request refused |

## Verification
Any wrong wait-counter load or state transition moves the next non-NOP command on the control lines. Every command is compared against an expected command and an exact cycle gap, so such a fault shows at the very next command after it. A wrong CAS pipeline stage shows as rd_valid one cycle early or late, or as data taken at the wrong edge, in the first read. A flag that is mishandled, such as a lost arm, a stray refresh or a missed self-refresh exit, shows as an unexpected command or a missing one, which is caught before the bench's next timeout.

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq #(
  parameter int DW      = 16,
  parameter int REFI_W  = 12,
  parameter int TRAS_W  = 4,
  parameter int TRP_W   = 3,
  parameter int TRCD_W  = 3,
  parameter int TWR_W   = 2,
  parameter int PU_REFS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_cl3,
  input  logic [TRAS_W-1:0] cfg_tras,
  input  logic [TRP_W-1:0]  cfg_trp,
  input  logic [TRCD_W-1:0] cfg_trcd,
  input  logic [TWR_W-1:0]  cfg_twr,
  input  logic [REFI_W-1:0] cfg_refi,
  input  logic              pwr_arm,
  input  logic              sref_req,
  input  logic              err_clr,
  input  logic              req_valid,
  input  logic              req_write,
  output logic              req_ack,
  input  logic [DW-1:0]     dq_in,
  output logic [DW-1:0]     rd_data,
  output logic              rd_valid,
  output logic              cke,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic              st_idle,
  output logic              st_sref,
  output logic              st_pwrup,
  output logic              st_err
);
  localparam int WT_W = ((TRAS_W > TRP_W) ? TRAS_W : TRP_W) + 2;
  localparam int PC_W = $clog2(PU_REFS + 1);
  localparam int SA_W = TRAS_W + 1;
  localparam logic [2:0] C_NOP = 3'b111, C_ACT = 3'b011, C_RD  = 3'b101,
                         C_WR  = 3'b100, C_PRE = 3'b010, C_REF = 3'b001,
                         C_MRS = 3'b000;

  typedef enum logic [2:0] {S_IDLE, S_PU_MRS, S_PU_REF, S_REF, S_SREF, S_RW, S_PRE} st_t;

  st_t              state;
  logic [WT_W-1:0]  wait_q;
  logic [TRAS_W-1:0] ras_cnt;
  logic [2:0]       cmd_q;
  logic             armed, pu_run, inited, ref_pend, sref_pend;
  logic [PC_W-1:0]  pu_cnt;
  logic [REFI_W-1:0] refi_cnt;
  logic [2:0]       rd_pipe;

  wire [TRAS_W-1:0] tras = (cfg_tras == '0) ? TRAS_W'(1) : cfg_tras;
  wire [TRP_W-1:0]  trp  = (cfg_trp  == '0) ? TRP_W'(1)  : cfg_trp;
  wire [TRCD_W-1:0] trcd = (cfg_trcd == '0) ? TRCD_W'(1) : cfg_trcd;
  wire [TWR_W-1:0]  twr  = (cfg_twr  == '0) ? TWR_W'(1)  : cfg_twr;

  wire [WT_W-1:0] ld_trp  = WT_W'(trp) - WT_W'(1);
  wire [WT_W-1:0] ld_rc   = WT_W'(tras) + WT_W'(trp) - WT_W'(1);
  wire            blocked = armed | pu_run;
  wire            cap     = cfg_cl3 ? rd_pipe[2] : rd_pipe[1];

  assign {ras_n, cas_n, we_n} = cmd_q;
  assign st_idle  = (state == S_IDLE) && (wait_q == '0);
  assign st_sref  = (state == S_SREF);
  assign st_pwrup = pu_run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;  wait_q <= '0;  ras_cnt <= '0;  cmd_q <= C_NOP;
      cke <= 1'b1;  req_ack <= 1'b0;  armed <= 1'b1;  pu_run <= 1'b0;
      inited <= 1'b0;  pu_cnt <= '0;  ref_pend <= 1'b0;  sref_pend <= 1'b0;
      refi_cnt <= '0;  st_err <= 1'b0;  rd_pipe <= '0;  rd_valid <= 1'b0;
      rd_data <= '0;
    end else begin
      cmd_q   <= C_NOP;
      req_ack <= 1'b0;
      rd_pipe <= {rd_pipe[1:0], 1'b0};
      if (ras_cnt != '0) ras_cnt <= ras_cnt - 1'b1;
      if (wait_q != '0)  wait_q  <= wait_q - 1'b1;
      rd_valid <= cap;
      if (cap) rd_data <= dq_in;
      st_err <= (st_err & ~err_clr) | (sref_req & blocked);
      if (sref_req && !blocked) sref_pend <= 1'b1;

      if (wait_q == '0) begin
        case (state)
          S_IDLE: begin
            if (ref_pend) begin
              cmd_q <= C_PRE;  wait_q <= ld_trp;  state <= S_REF;
            end else if (armed && req_valid) begin
              cmd_q <= C_PRE;  wait_q <= ld_trp;  armed <= 1'b0;
              pu_run <= 1'b1;  state <= S_PU_MRS;
            end else if (sref_pend) begin
              cmd_q <= C_REF;  cke <= 1'b0;  sref_pend <= 1'b0;  state <= S_SREF;
            end else if (req_valid) begin
              cmd_q <= C_ACT;  ras_cnt <= tras - TRAS_W'(1);
              wait_q <= WT_W'(trcd) - WT_W'(1);  state <= S_RW;
            end
          end
          S_PU_MRS: begin
            cmd_q <= C_MRS;  wait_q <= ld_trp;  pu_cnt <= '0;  state <= S_PU_REF;
          end
          S_PU_REF: begin
            cmd_q  <= C_REF;  wait_q <= ld_rc;  pu_cnt <= pu_cnt + 1'b1;
            if (pu_cnt == PC_W'(PU_REFS - 1)) begin
              pu_run <= 1'b0;  inited <= 1'b1;  state <= S_IDLE;
            end
          end
          S_REF: begin
            cmd_q <= C_REF;  wait_q <= ld_rc;  ref_pend <= 1'b0;  state <= S_IDLE;
          end
          S_SREF: begin
            if (req_valid) begin
              cke <= 1'b1;  wait_q <= ld_trp;  state <= S_IDLE;
            end
          end
          S_RW: begin
            cmd_q   <= req_write ? C_WR : C_RD;
            req_ack <= 1'b1;
            wait_q  <= req_write ? WT_W'(twr) - WT_W'(1) : '0;
            if (!req_write) rd_pipe[0] <= 1'b1;
            state <= S_PRE;
          end
          S_PRE: begin
            if (ras_cnt == '0) begin
              cmd_q <= C_PRE;  wait_q <= ld_trp;  state <= S_IDLE;
            end
          end
          default: state <= S_IDLE;
        endcase
      end

      if (!inited || state == S_SREF || cfg_refi == '0) refi_cnt <= cfg_refi;
      else if (refi_cnt == '0) begin
        ref_pend <= 1'b1;  refi_cnt <= cfg_refi;
      end else refi_cnt <= refi_cnt - 1'b1;

      if (pwr_arm) armed <= 1'b1;
    end
  end

  logic [SA_W-1:0] since_act;
  always_ff @(posedge clk) begin
    if (!rst_n) since_act <= '1;
    else if (cmd_q == C_ACT) since_act <= SA_W'(1);
    else if (since_act != '1) since_act <= since_act + 1'b1;
  end

  p_rcd_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == C_RD || cmd_q == C_WR) |-> since_act == SA_W'(trcd));
  p_ack_cmd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |-> (cmd_q == C_RD || cmd_q == C_WR));
  p_ras_min_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == C_PRE) |-> since_act >= SA_W'(tras));
  p_sref_cke_r9: assert property (@(posedge clk) disable iff (!rst_n)
    st_sref |-> !cke);
  p_sref_nop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke && $past(!cke)) |-> cmd_q == C_NOP);
  p_pu_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_pwrup) |-> cmd_q == C_PRE);
  p_err_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (st_err && !err_clr) |=> st_err);
  p_cas_lat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (cfg_cl3 ? $past(cmd_q == C_RD, 3) : $past(cmd_q == C_RD, 2)));
endmodule

// File: tb/sdram_cmd_seq_bench.sv
`timescale 1ns/1ps
module sdram_cmd_seq_bench;
  localparam int DW = 16;
  localparam logic [3:0] E_PRE = 4'b1010, E_MRS = 4'b1000, E_REF = 4'b1001,
                         E_ACT = 4'b1011, E_RD  = 4'b1101, E_WR  = 4'b1100,
                         E_SRE = 4'b0001, E_SRX = 4'b1111;

  logic clk = 0, rst_n = 0;
  logic cfg_cl3 = 0;
  logic [3:0] cfg_tras = 0;
  logic [2:0] cfg_trp = 0, cfg_trcd = 0;
  logic [1:0] cfg_twr = 0;
  logic [11:0] cfg_refi = 0;
  logic pwr_arm = 0, sref_req = 0, err_clr = 0, req_valid = 0, req_write = 0;
  logic [DW-1:0] dq_in = 0;
  logic req_ack, rd_valid, cke, ras_n, cas_n, we_n, st_idle, st_sref, st_pwrup, st_err;
  logic [DW-1:0] rd_data;

  always #2 clk = ~clk;

  sdram_cmd_seq u_sdram_cmd_seq (
    .clk(clk), .rst_n(rst_n), .cfg_cl3(cfg_cl3), .cfg_tras(cfg_tras), .cfg_trp(cfg_trp),
    .cfg_trcd(cfg_trcd), .cfg_twr(cfg_twr), .cfg_refi(cfg_refi), .pwr_arm(pwr_arm),
    .sref_req(sref_req), .err_clr(err_clr), .req_valid(req_valid), .req_write(req_write),
    .req_ack(req_ack), .dq_in(dq_in), .rd_data(rd_data), .rd_valid(rd_valid), .cke(cke),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .st_idle(st_idle), .st_sref(st_sref),
    .st_pwrup(st_pwrup), .st_err(st_err));

  int checks = 0, errors = 0, cyc = 0, last_ev = 0, rd_cyc = -1, n_ev = 0, cur_cl = 2;
  int e_tras, e_trp, e_trcd, e_twr;
  logic [3:0] q_ev[$];
  int q_gap[$];
  logic prev_cke = 1;

  function automatic logic [DW-1:0] fdq(int n);
    return DW'(n) ^ 16'hA5A5;
  endfunction
  function automatic int eff(int v);
    return (v == 0) ? 1 : v;
  endfunction
  function automatic int mx(int a, int b);
    return (a > b) ? a : b;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic push(logic [3:0] e, int g);
    q_ev.push_back(e);
    q_gap.push_back(g);
  endtask

  task automatic set_cfg(int tras, int trp, int trcd, int twr, bit cl3);
    cfg_tras = 4'(tras); cfg_trp = 3'(trp); cfg_trcd = 3'(trcd); cfg_twr = 2'(twr);
    cfg_cl3 = cl3; cur_cl = cl3 ? 3 : 2;
    e_tras = eff(tras); e_trp = eff(trp); e_trcd = eff(trcd); e_twr = eff(twr);
  endtask

  function automatic int pre_gap(bit w);
    return w ? mx(e_twr, e_tras - e_trcd) : mx(1, e_tras - e_trcd);
  endfunction

  task automatic wait_ack(string req);
    int t = 0;
    do begin @(negedge clk); t++; end while (!req_ack && t < 600);
    chk(req_ack, req, "request acknowledged", req_ack, 1);
  endtask

  task automatic drain();
    int t = 0;
    while ((q_ev.size() != 0 || rd_cyc >= 0) && t < 3000) begin @(negedge clk); t++; end
    chk(q_ev.size() == 0, "R1", "expected commands all seen", q_ev.size(), 0);
    repeat (40) @(negedge clk);
  endtask

  task automatic push_powerup();
    push(E_PRE, -1); push(E_MRS, e_trp); push(E_REF, e_trp);
    for (int k = 1; k < 8; k++) push(E_REF, e_tras + e_trp);
  endtask

  always @(negedge clk) begin
    logic [3:0] ev;
    cyc++;
    if (rst_n) begin
      ev = {cke, ras_n, cas_n, we_n};
      if (rd_valid) begin
        chk(rd_cyc >= 0 && cyc == rd_cyc + cur_cl, "R7", "read capture cycle", cyc - rd_cyc, cur_cl);
        chk(rd_data == fdq(rd_cyc + cur_cl - 1), "R7", "read data", int'(rd_data),
            int'(fdq(rd_cyc + cur_cl - 1)));
        rd_cyc = -1;
      end
      if (ev[2:0] != 3'b111 || cke != prev_cke) begin
        n_ev++;
        if (q_ev.size() == 0) chk(0, "R1", "unexpected command", int'(ev), -1);
        else begin
          logic [3:0] e;
          int g;
          e = q_ev.pop_front();
          g = q_gap.pop_front();
          chk(ev == e, "R1", "command code", int'(ev), int'(e));
          if (g >= 0) chk(cyc - last_ev == g, "R5", "gap to previous command", cyc - last_ev, g);
        end
        if (ev == E_RD) rd_cyc = cyc;
        if (ev == E_MRS) chk(st_pwrup == 1, "R3", "st_pwrup at mode set", st_pwrup, 1);
        if (ev == E_ACT) chk(st_pwrup == 0, "R3", "st_pwrup at activate", st_pwrup, 0);
        last_ev = cyc;
      end
      prev_cke = cke;
    end
    dq_in = fdq(cyc);
  end

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    set_cfg(5, 2, 3, 2, 0);
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk({ras_n, cas_n, we_n} == 3'b111 && cke, "R1", "reset NOP", int'({cke, ras_n, cas_n, we_n}), 15);
    chk(st_idle == 1, "R12", "idle after reset", st_idle, 1);
    chk(!st_sref && !st_pwrup && !st_err && !rd_valid, "R3", "status after reset",
        int'({st_sref, st_pwrup, st_err, rd_valid}), 0);

    // R2 initialization on first request, then read with CL2 (R4 R5 R7)
    push_powerup();
    push(E_ACT, e_tras + e_trp); push(E_RD, e_trcd); push(E_PRE, pre_gap(0));
    req_write = 0; req_valid = 1;
    wait_ack("R2");
    chk(st_idle == 0, "R12", "busy during access", st_idle, 0);
    req_valid = 0;
    drain();
    chk(st_idle == 1, "R12", "idle after access", st_idle, 1);

    // R4 R5 R6 R8 random back-to-back accesses; batch 0 all-zero fields, batch 1 maxima
    for (int b = 0; b < 4; b++) begin
      if (b == 0) set_cfg(0, 0, 0, 0, 0);
      else if (b == 1) set_cfg(15, 7, 7, 3, 1);
      else set_cfg($urandom % 16, $urandom % 8, $urandom % 8, $urandom % 4, 1'($urandom % 2));
      repeat (3) @(negedge clk);
      for (int i = 0; i < 25; i++) begin
        bit w;
        w = 1'($urandom % 2);
        push(E_ACT, (i == 0) ? -1 : e_trp);
        push(w ? E_WR : E_RD, e_trcd);
        push(E_PRE, pre_gap(w));
        req_write = w; req_valid = 1;
        wait_ack("R6");
      end
      req_valid = 0;
      drain();
    end

    // R11 periodic refresh with precharge first, request held off
    set_cfg(4, 3, 2, 1, 1);
    begin
      int target;
      target = n_ev + 4;
      push(E_PRE, -1); push(E_REF, e_trp); push(E_PRE, 41 - e_trp); push(E_REF, e_trp);
      cfg_refi = 12'd40;
      for (int t = 0; t < 300 && n_ev < target; t++) @(negedge clk);
      chk(n_ev >= target, "R11", "refresh pairs seen", n_ev, target);
      push(E_ACT, e_tras + e_trp); push(E_RD, e_trcd); push(E_PRE, pre_gap(0));
      cfg_refi = 12'd0;
      req_write = 0; req_valid = 1;
      wait_ack("R11");
      req_valid = 0;
      drain();
    end

    // R9 R10 self-refresh entry, hold, exit on request
    push(E_SRE, -1);
    sref_req = 1; @(negedge clk); sref_req = 0;
    repeat (10) @(negedge clk);
    chk(st_sref == 1 && cke == 0, "R9", "self-refresh held", int'({st_sref, cke}), 2);
    chk(st_idle == 0, "R12", "not idle in self-refresh", st_idle, 0);
    push(E_SRX, -1); push(E_ACT, e_trp); push(E_WR, e_trcd); push(E_PRE, pre_gap(1));
    req_write = 1; req_valid = 1;
    wait_ack("R10");
    req_valid = 0;
    drain();
    chk(st_sref == 0 && cke == 1, "R10", "self-refresh left", int'({st_sref, cke}), 1);

    // R13 refused self-refresh while armed, sticky error; R2 re-arm reruns initialization
    pwr_arm = 1; @(negedge clk); pwr_arm = 0;
    sref_req = 1; @(negedge clk); sref_req = 0;
    @(negedge clk);
    chk(st_err == 1, "R13", "error set", st_err, 1);
    repeat (10) @(negedge clk);
    chk(st_err == 1 && st_sref == 0 && cke == 1, "R13", "error held, request ignored",
        int'({st_err, st_sref, cke}), 5);
    err_clr = 1; @(negedge clk); err_clr = 0;
    @(negedge clk);
    chk(st_err == 0, "R13", "error cleared", st_err, 0);
    push_powerup();
    push(E_ACT, e_tras + e_trp); push(E_WR, e_trcd); push(E_PRE, pre_gap(1));
    req_write = 1; req_valid = 1;
    wait_ack("R2");
    req_valid = 0;
    drain();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule